// File: doc/BRIEF.md
# I2S Receive Deserializer with Sample FIFO

This block takes the serial data line of an I2S link and turns it into parallel audio samples. The bit clock and the word-select strobe come from a separate clock generator. This block sees the bit clock as a one-cycle sampling strobe in the system clock domain. Each channel slot is 32 bit periods long. A configurable number of leading bits in each slot, MSB first, form the sample. The sample is left-justified in a 32-bit word and the remaining bits of the slot are ignored.

Completed samples go into a 32-entry receive FIFO as left/right pairs. The left word is written first. The host pops the FIFO one word at a time. It sees a fill count, and a sticky data-full flag that is set when the fill count exceeds a programmable threshold. Two further sticky flags report overrun and underrun. Each flag drives a request output through its own enable. A flag is cleared by a flag write that carries 0 in that flag's bit; a 1 leaves the flag unchanged. A FIFO reset input empties the FIFO and holds it empty. The receiver then waits for a fresh left slot before it captures again, so the host only ever sees whole frames.

Top module: `i2s_rx_deser`

## Requirements
- R1: `word_len_i` selects the sample length. 0 means 16 bits, 1 means 24 bits, 2 or 3 means 32 bits. The first that many bits of a slot are taken MSB first and placed left-justified in the 32-bit word: a 16-bit sample sits in bits 31:16 and a 24-bit sample in bits 31:8. All lower bits are 0, and slot bits after the sample have no effect.
- R2: `ws_i` low marks a left slot and high marks a right slot. The bit sampled on the strobe where `ws_i` changes is the last bit of the slot that is ending. The left word of each frame is stored before its right word.
- R3: After reset, after `fifo_rst_i` is released, or after `rx_en_i` rises, nothing is stored until a left slot starts (`ws_i` falls) with the receiver enabled. From then on only complete left/right pairs are written.
- R4: The FIFO holds 32 words. `fill_o` gives the number of words held (0 to 32). Each stored pair adds 2 and each read removes 1.
- R5: The data-full flag (`flags_o[0]`) is set while `fill_o` is greater than `full_thr_i`, so a threshold of 0 sets it as soon as one word is held. The flag is sticky. A flag write with 0 in bit 0 clears it only when the fill level is no longer above the threshold. A 1 in bit 0 has no effect.
- R6: `full_req_o` equals the data-full flag gated by `full_ie_i`.
- R7: A pair that completes while fewer than two entries are free is dropped whole and sets the overrun flag (`flags_o[1]`). The FIFO contents and count stay unchanged. The flag stays set until a flag write with 0 in bit 1.
- R8: A read while the FIFO is empty returns 0 and sets the underrun flag (`flags_o[2]`). The flag stays set until a flag write with 0 in bit 2.
- R9: `err_req_o` is high when the overrun flag is set with `ovf_ie_i` high, or when the underrun flag is set with `unf_ie_i` high.
- R10: While `fifo_rst_i` is high, the FIFO is held empty, completed pairs are discarded, and reads return 0 without raising underrun.
- R11: While `rx_en_i` is low, no sample is written to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| fifo_rst_i | input | 1 | Holds the FIFO empty and disarms capture |
| word_len_i | input | 2 | Sample length select |
| bit_tick_i | input | 1 | One-cycle strobe at each bit-clock sampling edge |
| ws_i | input | 1 | Word select, low for left |
| sd_i | input | 1 | Serial data |
| rd_i | input | 1 | Pop one word |
| rdata_o | output | 32 | Head of the FIFO, 0 when empty |
| fill_o | output | 6 | Words held |
| full_thr_i | input | 5 | Data-full threshold |
| full_ie_i | input | 1 | Data-full request enable |
| ovf_ie_i | input | 1 | Overrun request enable |
| unf_ie_i | input | 1 | Underrun request enable |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 3 | Flag write data; 0 in a bit clears that flag |
| flags_o | output | 3 | Data-full, overrun, underrun flags |
| full_req_o | output | 1 | Data-full request |
| err_req_o | output | 1 | Error request |

## Verification
The bench sweeps all three sample lengths and drives 1s into the slot bits that follow each sample. A design that masks the wrong span, or that shifts the last bit of a 32-bit slot a strobe late, returns corrupted words. The FIFO is filled to exactly 32 entries, and a pair is then offered at 32 and at 31 entries. A design that stores half a pair or checks space for a single word would change the count or the contents. The threshold is tested at equality and one below, and the flags are tested with write-1 and write-0. Capture is restarted mid-stream after a FIFO reset and after enable. A design that arms on any slot edge would store a stray frame.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int SLOT_W = 32;

  typedef enum logic [1:0] {
    WL_16  = 2'd0,
    WL_24  = 2'd1,
    WL_32  = 2'd2,
    WL_32B = 2'd3
  } word_len_e;

  function automatic logic [5:0] word_bits(input logic [1:0] wl);
    case (word_len_e'(wl))
      WL_16:   return 6'd16;
      WL_24:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/i2s_rx_slot.sv
module i2s_rx_slot
  import i2s_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              flush_i,
  input  logic [1:0]        wl_i,
  input  logic              tick_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic              pair_vld_o,
  output logic [SLOT_W-1:0] left_o,
  output logic [SLOT_W-1:0] right_o
);
  localparam int CNT_W = $clog2(SLOT_W);

  logic              ws_q, armed_q, have_left_q;
  logic [CNT_W-1:0]  cnt_q, pos;
  logic [SLOT_W-1:0] sh_q, nsh, word, left_q;
  logic [CNT_W:0]    nbits;
  logic              chg;

  assign nbits = word_bits(wl_i);
  assign chg   = ws_i != ws_q;
  // the strobe on which ws toggles carries the last bit of the ending slot
  assign pos   = chg ? CNT_W'(SLOT_W - 1) : cnt_q;
  assign nsh   = ({1'b0, pos} < nbits) ? {sh_q[SLOT_W-2:0], sd_i} : sh_q;
  assign word  = nsh << ((CNT_W+1)'(SLOT_W) - nbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q        <= 1'b1;
      cnt_q       <= '0;
      sh_q        <= '0;
      armed_q     <= 1'b0;
      have_left_q <= 1'b0;
      left_q      <= '0;
      pair_vld_o  <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
    end else begin
      pair_vld_o <= 1'b0;
      if (tick_i) begin
        if (chg) begin
          cnt_q <= '0;
          sh_q  <= '0;
          ws_q  <= ws_i;
          if (armed_q) begin
            if (!ws_q) begin
              left_q      <= word;
              have_left_q <= 1'b1;
            end else if (have_left_q) begin
              pair_vld_o  <= 1'b1;
              left_o      <= left_q;
              right_o     <= word;
              have_left_q <= 1'b0;
            end
          end else if (!ws_i) begin
            armed_q     <= 1'b1;
            have_left_q <= 1'b0;
          end
        end else begin
          if (cnt_q != CNT_W'(SLOT_W - 1)) cnt_q <= cnt_q + 1'b1;
          sh_q <= nsh;
        end
      end
      if (!en_i || flush_i) begin
        armed_q     <= 1'b0;
        have_left_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   pair_vld_i,
  input  logic [DATA_W-1:0]      wd0_i,
  input  logic [DATA_W-1:0]      wd1_i,
  input  logic                   rd_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [$clog2(DEPTH):0] fill_o,
  output logic                   ovf_o,
  output logic                   unf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic              room, push, pop, empty;

  assign empty   = cnt_q == '0;
  assign room    = cnt_q <= CW'(DEPTH - 2);
  assign push    = pair_vld_i && !flush_i && room;
  assign pop     = rd_i && !flush_i && !empty;
  assign ovf_o   = pair_vld_i && !flush_i && !room;
  assign unf_o   = rd_i && !flush_i && empty;
  assign rdata_o = (!empty && !flush_i) ? mem[rp_q] : '0;
  assign fill_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push) begin
      mem[wp_q]           <= wd0_i;
      mem[wp_q + AW'(1)]  <= wd1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + AW'(2);
      if (pop)  rp_q <= rp_q + AW'(1);
      cnt_q <= cnt_q + (push ? CW'(2) : CW'(0)) - (pop ? CW'(1) : CW'(0));
    end
  end
endmodule

// File: rtl/i2s_rx_flags.sv
module i2s_rx_flags #(
  parameter int CW    = 6,
  parameter int THR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    fill_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             ovf_ev_i,
  input  logic             unf_ev_i,
  input  logic             wr_i,
  input  logic [2:0]       wdata_i,
  input  logic             full_ie_i,
  input  logic             ovf_ie_i,
  input  logic             unf_ie_i,
  output logic [2:0]       flags_o,
  output logic             full_req_o,
  output logic             err_req_o
);
  logic [2:0] set;

  assign set = {unf_ev_i, ovf_ev_i, fill_i > CW'(thr_i)};

  for (genvar i = 0; i < 3; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[i] <= 1'b0;
      else         flags_o[i] <= set[i] | (flags_o[i] & ~(wr_i & ~wdata_i[i]));
    end
  end

  assign full_req_o = flags_o[0] & full_ie_i;
  assign err_req_o  = (flags_o[1] & ovf_ie_i) | (flags_o[2] & unf_ie_i);
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser #(
  parameter int DEPTH = 32,
  parameter int THR_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rx_en_i,
  input  logic                   fifo_rst_i,
  input  logic [1:0]             word_len_i,
  input  logic                   bit_tick_i,
  input  logic                   ws_i,
  input  logic                   sd_i,
  input  logic                   rd_i,
  output logic [31:0]            rdata_o,
  output logic [$clog2(DEPTH):0] fill_o,
  input  logic [THR_W-1:0]       full_thr_i,
  input  logic                   full_ie_i,
  input  logic                   ovf_ie_i,
  input  logic                   unf_ie_i,
  input  logic                   flag_wr_i,
  input  logic [2:0]             flag_wdata_i,
  output logic [2:0]             flags_o,
  output logic                   full_req_o,
  output logic                   err_req_o
);
  import i2s_rx_pkg::*;
  localparam int CW = $clog2(DEPTH) + 1;

  logic              pair_vld, ovf_ev, unf_ev;
  logic [SLOT_W-1:0] left_w, right_w;

  i2s_rx_slot u_slot (
    .clk_i, .rst_ni,
    .en_i       (rx_en_i),
    .flush_i    (fifo_rst_i),
    .wl_i       (word_len_i),
    .tick_i     (bit_tick_i),
    .ws_i, .sd_i,
    .pair_vld_o (pair_vld),
    .left_o     (left_w),
    .right_o    (right_w)
  );

  i2s_rx_fifo #(.DATA_W(SLOT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i    (fifo_rst_i),
    .pair_vld_i (pair_vld),
    .wd0_i      (left_w),
    .wd1_i      (right_w),
    .rd_i,
    .rdata_o,
    .fill_o,
    .ovf_o      (ovf_ev),
    .unf_o      (unf_ev)
  );

  i2s_rx_flags #(.CW(CW), .THR_W(THR_W)) u_flags (
    .clk_i, .rst_ni,
    .fill_i     (fill_o),
    .thr_i      (full_thr_i),
    .ovf_ev_i   (ovf_ev),
    .unf_ev_i   (unf_ev),
    .wr_i       (flag_wr_i),
    .wdata_i    (flag_wdata_i),
    .full_ie_i, .ovf_ie_i, .unf_ie_i,
    .flags_o,
    .full_req_o,
    .err_req_o
  );
endmodule

// File: rtl/i2s_rx_deser_chk.sv
module i2s_rx_deser_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fifo_rst_i,
  input logic        rd_i,
  input logic [31:0] rdata_o,
  input logic [5:0]  fill_o,
  input logic [2:0]  flags_o,
  input logic        full_ie_i,
  input logic        full_req_o,
  input logic        flag_wr_i,
  input logic [2:0]  flag_wdata_i
);
  a_r4_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= 6'd32);

  a_r4_fill_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_rst_i |=> (fill_o == $past(fill_o)) || (fill_o == $past(fill_o) + 6'd1) ||
                    (fill_o == $past(fill_o) + 6'd2) || (fill_o == $past(fill_o) - 6'd1));

  a_r10_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> fill_o == 6'd0);

  a_r8_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o == 6'd0 |-> rdata_o == 32'd0);

  a_r8_unf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && fill_o == 6'd0 && !fifo_rst_i |=> flags_o[2]);

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] && !(flag_wr_i && !flag_wdata_i[1]) |=> flags_o[1]);

  a_r6_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_ie_i |-> !full_req_o);
endmodule

bind i2s_rx_deser i2s_rx_deser_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_rst_i   (fifo_rst_i),
  .rd_i         (rd_i),
  .rdata_o      (rdata_o),
  .fill_o       (fill_o),
  .flags_o      (flags_o),
  .full_ie_i    (full_ie_i),
  .full_req_o   (full_req_o),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i)
);

// File: tb/i2s_rx_deser_test.sv
module i2s_rx_deser_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_en_i = 1'b1;
  logic        fifo_rst_i = 1'b0;
  logic [1:0]  word_len_i = 2'd0;
  logic        bit_tick_i = 1'b0;
  logic        ws_i = 1'b1;
  logic        sd_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [5:0]  fill_o;
  logic [4:0]  full_thr_i = 5'd0;
  logic        full_ie_i = 1'b1;
  logic        ovf_ie_i = 1'b1;
  logic        unf_ie_i = 1'b1;
  logic        flag_wr_i = 1'b0;
  logic [2:0]  flag_wdata_i = 3'b111;
  logic [2:0]  flags_o;
  logic        full_req_o;
  logic        err_req_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  i2s_rx_deser uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic w, input logic d);
    @(negedge clk_i);
    ws_i = w; sd_i = d; bit_tick_i = 1'b1;
    @(negedge clk_i);
    bit_tick_i = 1'b0;
    @(negedge clk_i);
  endtask

  // ws moves to the next channel on the last bit of a slot
  task automatic send_slot(input logic ch, input logic [31:0] val, input int n, input logic nxt);
    for (int p = 0; p < 32; p++)
      tick(p == 31 ? nxt : ch, p < n ? val[31-p] : 1'b1);
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int n);
    send_slot(1'b0, l, n, 1'b1);
    send_slot(1'b1, r, n, 1'b0);
  endtask

  task automatic preamble();
    send_slot(1'b1, 32'h0, 32, 1'b0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic expect_frame(input logic [31:0] l, input logic [31:0] r, input int n);
    logic [31:0] m;
    m = 32'hFFFF_FFFF << (32 - n);
    exp_q.push_back(l & m);
    exp_q.push_back(r & m);
  endtask

  task automatic rd_word(output logic [31:0] d);
    @(negedge clk_i);
    rd_i = 1'b1;
    d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic drain(input string req, input int k);
    logic [31:0] d, e;
    for (int i = 0; i < k; i++) begin
      rd_word(d);
      e = exp_q.pop_front();
      chk(req, d, e);
    end
  endtask

  task automatic wr_flags(input logic [2:0] w);
    @(negedge clk_i);
    flag_wr_i = 1'b1; flag_wdata_i = w;
    @(negedge clk_i);
    flag_wr_i = 1'b0; flag_wdata_i = 3'b111;
  endtask

  task automatic pulse_frst();
    @(negedge clk_i);
    fifo_rst_i = 1'b1;
    @(negedge clk_i);
    fifo_rst_i = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int k, input int ch);
    return (32'h9E37_79B9 * 32'(k + 1)) ^ (ch != 0 ? 32'hC3A5_0F1E : 32'h0);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R4 reset fill", 32'(fill_o), 32'd0);
    chk("R5 reset flags", 32'(flags_o), 32'd0);
    chk("R6 reset full_req", 32'(full_req_o), 32'd0);
    chk("R9 reset err_req", 32'(err_req_o), 32'd0);

    // R1 R2: sweep every sample length, junk after the sample
    for (int m = 0; m < 3; m++) begin
      n = (m == 0) ? 16 : (m == 1) ? 24 : 32;
      word_len_i = 2'(m);
      pulse_frst();
      preamble();
      for (int f = 0; f < 3; f++) begin
        send_frame(pat(f + 10*m, 0), pat(f + 10*m, 1), n);
        expect_frame(pat(f + 10*m, 0), pat(f + 10*m, 1), n);
      end
      settle();
      chk("R4 fill after three frames", 32'(fill_o), 32'd6);
      if (m == 0) chk("R5 threshold zero sets flag", 32'(flags_o[0]), 32'd1);
      drain("R1 R2 word data and order", 6);
    end
    wr_flags(3'b110);
    chk("R5 clear when below threshold", 32'(flags_o[0]), 32'd0);

    // R5 R6 threshold
    word_len_i = 2'd2; n = 32;
    full_thr_i = 5'd3;
    pulse_frst();
    preamble();
    send_frame(pat(40, 0), pat(40, 1), n); expect_frame(pat(40, 0), pat(40, 1), n);
    settle();
    chk("R5 fill 2 under thr 3", 32'(flags_o[0]), 32'd0);
    chk("R6 no request", 32'(full_req_o), 32'd0);
    full_thr_i = 5'd4;
    send_frame(pat(41, 0), pat(41, 1), n); expect_frame(pat(41, 0), pat(41, 1), n);
    settle();
    chk("R4 fill 4", 32'(fill_o), 32'd4);
    chk("R5 fill equal to thr", 32'(flags_o[0]), 32'd0);
    full_thr_i = 5'd3;
    settle();
    chk("R5 fill above thr", 32'(flags_o[0]), 32'd1);
    chk("R6 request on", 32'(full_req_o), 32'd1);
    full_ie_i = 1'b0;
    @(negedge clk_i);
    chk("R6 request gated", 32'(full_req_o), 32'd0);
    full_ie_i = 1'b1;
    drain("R1 R2 threshold data", 2);
    settle();
    chk("R5 flag sticky", 32'(flags_o[0]), 32'd1);
    wr_flags(3'b111);
    chk("R5 write one no effect", 32'(flags_o[0]), 32'd1);
    wr_flags(3'b110);
    chk("R5 write zero clears", 32'(flags_o[0]), 32'd0);
    drain("R1 R2 threshold data", 2);

    // R8 R9 underrun
    rd_word(d);
    chk("R8 empty read data", d, 32'd0);
    chk("R8 underrun flag", 32'(flags_o[2]), 32'd1);
    chk("R9 err request unf", 32'(err_req_o), 32'd1);
    unf_ie_i = 1'b0;
    @(negedge clk_i);
    chk("R9 unf gated", 32'(err_req_o), 32'd0);
    unf_ie_i = 1'b1;
    wr_flags(3'b011);
    chk("R8 underrun cleared", 32'(flags_o[2]), 32'd0);

    // R7 overrun at 32 and 31 entries
    pulse_frst();
    preamble();
    for (int f = 0; f < 16; f++) begin
      send_frame(pat(50 + f, 0), pat(50 + f, 1), n);
      expect_frame(pat(50 + f, 0), pat(50 + f, 1), n);
    end
    settle();
    chk("R4 full count", 32'(fill_o), 32'd32);
    chk("R7 no overrun yet", 32'(flags_o[1]), 32'd0);
    send_frame(pat(70, 0), pat(70, 1), n);
    settle();
    chk("R7 count kept", 32'(fill_o), 32'd32);
    chk("R7 overrun flag", 32'(flags_o[1]), 32'd1);
    chk("R9 err request ovf", 32'(err_req_o), 32'd1);
    wr_flags(3'b101);
    chk("R7 overrun cleared", 32'(flags_o[1]), 32'd0);
    drain("R7 head intact", 1);
    send_frame(pat(71, 0), pat(71, 1), n);
    settle();
    chk("R7 pair dropped at 31", 32'(fill_o), 32'd31);
    chk("R7 overrun at 31", 32'(flags_o[1]), 32'd1);
    drain("R7 contents intact", 31);
    chk("R4 drained", 32'(fill_o), 32'd0);
    wr_flags(3'b100);

    // R10 FIFO reset
    send_frame(pat(80, 0), pat(80, 1), n);
    settle();
    chk("R4 fill before reset", 32'(fill_o), 32'd2);
    @(negedge clk_i); fifo_rst_i = 1'b1;
    settle();
    chk("R10 held empty", 32'(fill_o), 32'd0);
    send_frame(pat(81, 0), pat(81, 1), n);
    settle();
    chk("R10 pair discarded", 32'(fill_o), 32'd0);
    rd_word(d);
    chk("R10 read data zero", d, 32'd0);
    chk("R10 no underrun", 32'(flags_o[2]), 32'd0);
    @(negedge clk_i); fifo_rst_i = 1'b0;
    send_frame(pat(82, 0), pat(82, 1), n);
    settle();
    chk("R3 unarmed after reset", 32'(fill_o), 32'd0);
    send_frame(pat(83, 0), pat(83, 1), n); expect_frame(pat(83, 0), pat(83, 1), n);
    settle();
    chk("R3 first full frame", 32'(fill_o), 32'd2);
    drain("R3 frame data", 2);

    // R11 R3 enable
    rx_en_i = 1'b0;
    send_frame(pat(90, 0), pat(90, 1), n);
    settle();
    chk("R11 disabled no write", 32'(fill_o), 32'd0);
    rx_en_i = 1'b1;
    send_frame(pat(91, 0), pat(91, 1), n);
    settle();
    chk("R3 mid-stream enable", 32'(fill_o), 32'd0);
    send_frame(pat(92, 0), pat(92, 1), n); expect_frame(pat(92, 0), pat(92, 1), n);
    settle();
    chk("R3 pair after enable", 32'(fill_o), 32'd2);
    drain("R3 enable data", 2);

    finish_run();
  end
endmodule